// File: doc/BRIEF.md
# Two-Requester Priority-Swapping Memory Arbiter

This block decides which of two processors may use a single shared memory. Each processor raises its own request line. The arbiter answers with two grant lines, and at most one of them is high at any time. A processor that asks while the other is silent gets the memory on the next clock edge. A grant stays in place for as long as its owner keeps requesting. When that request drops, the arbiter goes back to idle for one cycle and only then serves anyone else.

Priority is a single token that is held by one processor. When both processors ask in the same idle cycle, the token holder wins. The token then passes to the processor that lost. An uncontested grant never moves the token. After reset the token belongs to processor 1.

The controller is a six-state Moore machine, so the grants are a function of the state register alone. A parameter selects how the state is stored. One choice is a dense 3-bit code read out through a 3-to-8 decoder. The other is a six-flop one-hot register. Both choices produce identical grant sequences for any request sequence.

Top module: `mem_arbiter2`

## Requirements
- R1: A synchronous active-high reset forces both grants low and gives the priority token to processor 1. A contest in the first idle cycle after reset is therefore won by processor 1.
- R2: gnt1 and gnt2 are never high together.
- R3: From idle, a request from only one processor raises that processor's grant on the next clock edge and leaves the priority token where it was.
- R4: From idle, when both requests are high, the token holder's grant rises on the next edge and the token moves to the other processor.
- R5: While a processor is granted and keeps its request high, its grant stays high. The other request has no effect during this time.
- R6: When the granted processor drops its request, both grants are low after the next edge, even if the other request is pending. The pending request is granted one edge later.
- R7: Grants change only at clock edges. A change on the request lines between edges leaves the grant outputs unchanged until the next edge.
- R8: The binary-coded variant (ONE_HOT=0) and the one-hot variant (ONE_HOT=1) produce identical grant sequences, cycle for cycle, under the same stimulus.
- R9: In the one-hot variant, exactly one state flop is set in every cycle after reset.
- R10: In the binary variant, the state code always stays within the six used codes 0 to 5, and decoder lines 6 and 7 are never active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req1 | input | 1 | Memory request from processor 1 |
| req2 | input | 1 | Memory request from processor 2 |
| gnt1 | output | 1 | Memory granted to processor 1 |
| gnt2 | output | 1 | Memory granted to processor 2 |

## Verification
The hardest situation to reach is a contest while processor 2 holds the token. That situation exists only after an earlier contest, or after a lone grant that followed one, and nothing at the ports shows the token directly. The vector table therefore builds it on purpose: a contest, a release, then further lone requests and contests, with each expected grant set worked out by hand. A long random run then drives both encodings side by side against a behavioural model of owner and token, so that every state is visited from many different histories.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int NUM_STATES = 6;
    localparam int STATE_W    = $clog2(NUM_STATES);

    // State codes; the one-hot variant uses the same values as bit indices.
    // Name reads as <who holds memory>_<who holds the priority token>.
    localparam logic [STATE_W-1:0] ST_IDLE_T1 = 3'd0;
    localparam logic [STATE_W-1:0] ST_IDLE_T2 = 3'd1;
    localparam logic [STATE_W-1:0] ST_OWN1_T1 = 3'd2;
    localparam logic [STATE_W-1:0] ST_OWN1_T2 = 3'd3;
    localparam logic [STATE_W-1:0] ST_OWN2_T2 = 3'd4;
    localparam logic [STATE_W-1:0] ST_OWN2_T1 = 3'd5;

    typedef struct packed {
        logic r1;
        logic r2;
    } arb_req_t;

    typedef struct packed {
        logic g1;
        logic g2;
    } arb_gnt_t;

    // Next-state function for the dense encoding; codes 6 and 7 fall to reset state.
    function automatic logic [STATE_W-1:0] arb_next(input logic [STATE_W-1:0] cur,
                                                    input arb_req_t rq);
        logic [STATE_W-1:0] nxt;
        nxt = ST_IDLE_T1;
        case (cur)
            ST_IDLE_T1: begin
                if (rq.r1 && rq.r2)  nxt = ST_OWN1_T2;
                else if (rq.r1)      nxt = ST_OWN1_T1;
                else if (rq.r2)      nxt = ST_OWN2_T1;
                else                 nxt = ST_IDLE_T1;
            end
            ST_IDLE_T2: begin
                if (rq.r1 && rq.r2)  nxt = ST_OWN2_T1;
                else if (rq.r1)      nxt = ST_OWN1_T2;
                else if (rq.r2)      nxt = ST_OWN2_T2;
                else                 nxt = ST_IDLE_T2;
            end
            ST_OWN1_T1: nxt = rq.r1 ? ST_OWN1_T1 : ST_IDLE_T1;
            ST_OWN1_T2: nxt = rq.r1 ? ST_OWN1_T2 : ST_IDLE_T2;
            ST_OWN2_T2: nxt = rq.r2 ? ST_OWN2_T2 : ST_IDLE_T2;
            ST_OWN2_T1: nxt = rq.r2 ? ST_OWN2_T1 : ST_IDLE_T1;
            default:    nxt = ST_IDLE_T1;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/arb_dec.sv
module arb_dec #(
    parameter int IN_W = 3
) (
    input  logic [IN_W-1:0]       code,
    output logic [(1<<IN_W)-1:0]  line
);
    localparam int OUT_N = 1 << IN_W;

    for (genvar i = 0; i < OUT_N; i++) begin : g_line
        assign line[i] = (code == i[IN_W-1:0]);
    end
endmodule

// File: rtl/arb_state_bin.sv
module arb_state_bin
    import arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  arb_req_t rq,
    output arb_gnt_t gn
);
    localparam int DEC_N = 1 << STATE_W;

    logic [STATE_W-1:0] st_q;
    logic [DEC_N-1:0]   dline;

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE_T1;
        else     st_q <= arb_next(st_q, rq);
    end

    arb_dec #(.IN_W(STATE_W)) u_dec (
        .code (st_q),
        .line (dline)
    );

    assign gn.g1 = dline[ST_OWN1_T1] | dline[ST_OWN1_T2];
    assign gn.g2 = dline[ST_OWN2_T2] | dline[ST_OWN2_T1];

    // R10: unused codes stay unreachable
    assert_code_range_R10: assert property (@(posedge clk) disable iff (rst)
        !(dline[6] || dline[7]));

    // R4: contest from token-1 idle hands memory to 1 and token to 2
    assert_swap_bin_R4: assert property (@(posedge clk) disable iff (rst)
        (dline[ST_IDLE_T1] && rq.r1 && rq.r2) |=> (st_q == ST_OWN1_T2));
endmodule

// File: rtl/arb_state_onehot.sv
module arb_state_onehot
    import arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  arb_req_t rq,
    output arb_gnt_t gn
);
    logic [NUM_STATES-1:0] oh_q;
    logic [NUM_STATES-1:0] oh_d;
    logic x, y;

    assign x = rq.r1;
    assign y = rq.r2;

    // Per-flop sum-of-products excitation
    always_comb begin
        oh_d[ST_IDLE_T1] = (oh_q[ST_IDLE_T1] & ~x & ~y) | (oh_q[ST_OWN1_T1] & ~x)
                         | (oh_q[ST_OWN2_T1] & ~y);
        oh_d[ST_IDLE_T2] = (oh_q[ST_IDLE_T2] & ~x & ~y) | (oh_q[ST_OWN1_T2] & ~x)
                         | (oh_q[ST_OWN2_T2] & ~y);
        oh_d[ST_OWN1_T1] = (oh_q[ST_IDLE_T1] & x & ~y) | (oh_q[ST_OWN1_T1] & x);
        oh_d[ST_OWN1_T2] = (oh_q[ST_IDLE_T1] & x & y) | (oh_q[ST_IDLE_T2] & x & ~y)
                         | (oh_q[ST_OWN1_T2] & x);
        oh_d[ST_OWN2_T2] = (oh_q[ST_IDLE_T2] & ~x & y) | (oh_q[ST_OWN2_T2] & y);
        oh_d[ST_OWN2_T1] = (oh_q[ST_IDLE_T2] & x & y) | (oh_q[ST_IDLE_T1] & ~x & y)
                         | (oh_q[ST_OWN2_T1] & y);
    end

    always_ff @(posedge clk) begin
        if (rst) oh_q <= NUM_STATES'(1) << ST_IDLE_T1;
        else     oh_q <= oh_d;
    end

    assign gn.g1 = oh_q[ST_OWN1_T1] | oh_q[ST_OWN1_T2];
    assign gn.g2 = oh_q[ST_OWN2_T2] | oh_q[ST_OWN2_T1];

    // R9: exactly one hot flop
    assert_one_hot_R9: assert property (@(posedge clk) disable iff (rst)
        $countones(oh_q) == 1);

    // R4: contest from token-2 idle hands memory to 2 and token to 1
    assert_swap_oh_R4: assert property (@(posedge clk) disable iff (rst)
        (oh_q[ST_IDLE_T2] && x && y) |=> oh_q[ST_OWN2_T1]);
endmodule

// File: rtl/mem_arbiter2.sv
module mem_arbiter2
    import arb_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic req1,
    input  logic req2,
    output logic gnt1,
    output logic gnt2
);
    arb_req_t rq;
    arb_gnt_t gn;

    assign rq.r1 = req1;
    assign rq.r2 = req2;

    if (ONE_HOT) begin : g_onehot
        arb_state_onehot u_core (.clk(clk), .rst(rst), .rq(rq), .gn(gn));
    end else begin : g_binary
        arb_state_bin u_core (.clk(clk), .rst(rst), .rq(rq), .gn(gn));
    end

    assign gnt1 = gn.g1;
    assign gnt2 = gn.g2;

    // R1
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!gnt1 && !gnt2));
    // R2
    assert_mutex_R2: assert property (@(posedge clk) disable iff (rst)
        !(gnt1 && gnt2));
    // R3
    assert_lone_grant_R3: assert property (@(posedge clk) disable iff (rst)
        (!gnt1 && !gnt2 && req1 && !req2) |=> gnt1);
    // R5
    assert_hold1_R5: assert property (@(posedge clk) disable iff (rst)
        (gnt1 && req1) |=> gnt1);
    assert_hold2_R5: assert property (@(posedge clk) disable iff (rst)
        (gnt2 && req2) |=> gnt2);
    // R6
    assert_release1_R6: assert property (@(posedge clk) disable iff (rst)
        (gnt1 && !req1) |=> (!gnt1 && !gnt2));
    assert_release2_R6: assert property (@(posedge clk) disable iff (rst)
        (gnt2 && !req2) |=> (!gnt1 && !gnt2));
endmodule

// File: tb/tb_mem_arbiter2.sv
module tb_mem_arbiter2;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 18;
    localparam int NRAND = 3000;

    // {req1, req2, exp_gnt1, exp_gnt2, requirement number}
    typedef struct packed {
        logic       x;
        logic       y;
        logic       g1;
        logic       g2;
        logic [3:0] rq;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{1'b0,1'b0,1'b0,1'b0,4'd1},  // idle after reset
        '{1'b1,1'b1,1'b1,1'b0,4'd1},  // R1: first contest goes to 1
        '{1'b1,1'b1,1'b1,1'b0,4'd5},  // R5: hold, other ignored
        '{1'b0,1'b1,1'b0,1'b0,4'd6},  // R6: release to idle, 2 waits
        '{1'b0,1'b1,1'b0,1'b1,4'd6},  // R6: 2 granted one edge later
        '{1'b1,1'b1,1'b0,1'b1,4'd5},  // R5: hold
        '{1'b1,1'b0,1'b0,1'b0,4'd6},  // release
        '{1'b1,1'b1,1'b0,1'b1,4'd4},  // R4: token was at 2
        '{1'b0,1'b0,1'b0,1'b0,4'd6},
        '{1'b1,1'b1,1'b1,1'b0,4'd4},  // R4: token back at 1
        '{1'b0,1'b0,1'b0,1'b0,4'd6},
        '{1'b1,1'b0,1'b1,1'b0,4'd3},  // R3: lone grant while token at 2
        '{1'b0,1'b0,1'b0,1'b0,4'd6},
        '{1'b1,1'b1,1'b0,1'b1,4'd3},  // R3: token stayed at 2
        '{1'b0,1'b0,1'b0,1'b0,4'd6},
        '{1'b1,1'b0,1'b1,1'b0,4'd3},  // lone with token at 1
        '{1'b0,1'b0,1'b0,1'b0,4'd6},
        '{1'b1,1'b1,1'b1,1'b0,4'd3}   // token still at 1
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req1 = 1'b0;
    logic req2 = 1'b0;
    logic b_g1, b_g2, o_g1, o_g2;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_arbiter2 #(.ONE_HOT(1'b0)) dut (
        .clk(clk), .rst(rst), .req1(req1), .req2(req2), .gnt1(b_g1), .gnt2(b_g2)
    );
    mem_arbiter2 #(.ONE_HOT(1'b1)) dut_oh (
        .clk(clk), .rst(rst), .req1(req1), .req2(req2), .gnt1(o_g1), .gnt2(o_g2)
    );

    task automatic chk(input int r, input logic [1:0] act, input logic [1:0] exp,
                       input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %b expected %b", r, what, act, exp);
        end
    endtask

    // Check both encodings against an expected grant pair; R8 covers agreement.
    task automatic chk_both(input int r, input logic [1:0] exp);
        chk(r, {b_g1, b_g2}, exp, "binary grants");
        chk(r, {o_g1, o_g2}, exp, "one-hot grants");
    endtask

    task automatic step(input logic x, input logic y);
        @(negedge clk);
        req1 = x;
        req2 = y;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req1 = 1'b0;
        req2 = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int owner;
        int token;
        logic x, y;

        do_reset();
        chk_both(1, 2'b00);  // R1 reset state

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i].x, VEC[i].y);
            chk_both(int'(VEC[i].rq), {VEC[i].g1, VEC[i].g2});
        end

        // R7: mid-cycle request change does not move grants
        do_reset();
        @(negedge clk);
        req1 = 1'b1;
        #2;
        chk_both(7, 2'b00);
        req1 = 1'b0;
        req2 = 1'b1;
        #1;
        chk_both(7, 2'b00);
        @(posedge clk);
        #1;
        chk_both(7, 2'b01);

        // R1: reset during a grant restores idle and token at 1
        step(1'b1, 1'b1);
        chk_both(5, 2'b01);
        do_reset();
        chk_both(1, 2'b00);
        step(1'b1, 1'b1);
        chk_both(1, 2'b10);

        // R8/R2: random run, both encodings against a behavioural model
        do_reset();
        owner = 0;
        token = 1;
        for (int k = 0; k < NRAND; k++) begin
            x = 1'($urandom);
            y = 1'($urandom);
            if (owner == 0) begin
                if (x && y) begin
                    owner = token;
                    token = (token == 1) ? 2 : 1;
                end else if (x) owner = 1;
                else if (y) owner = 2;
            end else if ((owner == 1 && !x) || (owner == 2 && !y)) begin
                owner = 0;
            end
            step(x, y);
            chk(8, {b_g1, b_g2}, {o_g1, o_g2}, "encodings disagree");
            chk(2, {b_g1, b_g2}, {owner == 1, owner == 2}, "random model");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule